// File: doc/BRIEF.md
# Predicate Register File with Parallel Compare

This block keeps a file of one-bit predicate registers and updates it with compare operations. Each compare evaluates a relation between two 64-bit operands and writes a pair of target predicates in one step. Several compare lanes can issue in the same clock cycle, so a group of compares can build a wide AND or OR into one predicate pair in a single cycle. A compare can also be spread over several cycles.

Besides the ordinary compare, the unit offers four other write types. The unconditional type clears both targets when its qualifying predicate is false. The accumulating AND and OR types write the same value to both targets. The two complementary accumulating types keep the pair as a value and its inverse. All accumulating types write only when the write would change the target, so lanes of the same type that aim at one predicate in the same cycle never disagree.

A consumer slot reads one predicate through a guard port. When that predicate is false, the consumer's result must not commit. The whole predicate vector is also presented as an output.

Top module: `pcmp_unit`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears predicates 1 to 63. Predicate 0 reads 1.
- R2: Predicate 0 always reads 1. Any lane write aimed at index 0 is discarded.
- R3: Type code 0 (normal) with a true qualifying predicate writes the condition c to target 1 and !c to target 2. With a false qualifying predicate it changes nothing.
- R4: Type code 1 (unconditional) behaves like type 0 when the qualifying predicate is true. When it is false, it writes 0 to both targets.
- R5: Type code 2 (AND) with a true qualifying predicate and c = 0 writes 0 to both targets. When c = 1 both targets keep their values.
- R6: Type code 3 (OR) with a true qualifying predicate and c = 1 writes 1 to both targets. When c = 0 both targets keep their values.
- R7: Type code 4 (AND into target 1, OR-complement into target 2) with a true qualifying predicate and c = 0 writes target 1 = 0 and target 2 = 1. Otherwise it writes nothing.
- R8: Type code 5 (OR into target 1, AND-complement into target 2) with a true qualifying predicate and c = 1 writes target 1 = 1 and target 2 = 0. Otherwise it writes nothing.
- R9: Relation code 0 is equal, 1 is not equal, 2 is signed less-than (A < B), and 3 is signed greater-or-equal (A >= B).
- R10: When imm_sel is set, operand A is the 14-bit immediate sign-extended to 64 bits in place of the register operand.
- R11: All lanes of one cycle read the qualifying predicates from the file as it stood before that cycle, and their writes land together at the clock edge. When two writes hit one index, the higher lane wins, and within a lane the target-2 write wins. Four type-4 lanes on one pair yield AND in target 1 and NAND in target 2.
- R12: The accumulating types 2 to 5 write nothing when the qualifying predicate is false. Reserved type codes 6 and 7, and lanes whose valid bit is low, never write.
- R13: cons_en equals cons_valid ANDed with the predicate selected by cons_qp, as it stood before this cycle's compares.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | NLANE | Lane issues a compare |
| cmp_type | input | NLANE x 3 | Write type code per lane |
| cmp_rel | input | NLANE x 2 | Relation code per lane |
| cmp_imm_sel | input | NLANE | Use the immediate as operand A |
| cmp_imm | input | NLANE x IMM_W | Immediate operand |
| cmp_opa | input | NLANE x DATA_W | Register operand A |
| cmp_opb | input | NLANE x DATA_W | Register operand B |
| cmp_qp | input | NLANE x PIDX_W | Qualifying predicate index |
| cmp_t1 | input | NLANE x PIDX_W | First target index |
| cmp_t2 | input | NLANE x PIDX_W | Second target index |
| cons_valid | input | 1 | Consumer slot holds an instruction |
| cons_qp | input | PIDX_W | Consumer guard predicate index |
| cons_en | output | 1 | Consumer may commit its result |
| pred_vec | output | NPRED | Current predicate file contents |

## Verification
The assertions check on every cycle that predicate 0 stays at 1. They check that the file holds still in any cycle with no write enable. They check that the highest lane's target-2 write always lands, and that each lane's write enables obey its qualifying predicate, including the unconditional clear and the complementary pair. Only the bench's scenarios can show the relation and immediate arithmetic, the accumulation of four lanes into an AND/NAND pair, the lane priority on conflicting indices, and the guard value the consumer sees before an update lands. The bench compares every cycle against its own model of the predicate file.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;

   typedef enum logic [1:0] {
      REL_EQ = 2'd0,
      REL_NE = 2'd1,
      REL_LT = 2'd2,
      REL_GE = 2'd3
   } rel_e;

   typedef enum logic [2:0] {
      CT_NORM    = 3'd0,
      CT_UNC     = 3'd1,
      CT_AND     = 3'd2,
      CT_OR      = 3'd3,
      CT_ANDORCM = 3'd4,
      CT_ORANDCM = 3'd5,
      CT_RSV6    = 3'd6,
      CT_RSV7    = 3'd7
   } ctype_e;

   typedef struct packed {
      logic we1;
      logic we2;
      logic v1;
      logic v2;
   } pwr_t;

endpackage

// File: rtl/pcmp_cond.sv
module pcmp_cond #(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 14
) (
   input  logic [1:0]        rel,
   input  logic              imm_sel,
   input  logic [IMM_W-1:0]  imm,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic              cond
);
   import pcmp_pkg::*;

   logic [DATA_W-1:0] imm_x;
   logic [DATA_W-1:0] a_sel;

   generate
      if (IMM_W < DATA_W) begin : g_sext
         assign imm_x = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
      end else begin : g_full
         assign imm_x = imm[DATA_W-1:0];
      end
   endgenerate

   assign a_sel = imm_sel ? imm_x : opa;

   always_comb begin
      case (rel_e'(rel))
         REL_EQ:  cond = (a_sel == opb);
         REL_NE:  cond = (a_sel != opb);
         REL_LT:  cond = ($signed(a_sel) <  $signed(opb));
         default: cond = ($signed(a_sel) >= $signed(opb));
      endcase
   end

endmodule

// File: rtl/pcmp_lane_upd.sv
module pcmp_lane_upd (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            valid,
   input  logic [2:0]      ctype,
   input  logic            qp,
   input  logic            cond,
   output pcmp_pkg::pwr_t  wr
);
   import pcmp_pkg::*;

   always_comb begin
      wr = '0;
      if (valid) begin
         case (ctype_e'(ctype))
            CT_NORM: if (qp) begin
               wr = '{we1: 1'b1, we2: 1'b1, v1: cond, v2: !cond};
            end
            CT_UNC: begin
               wr = '{we1: 1'b1, we2: 1'b1, v1: qp & cond, v2: qp & !cond};
            end
            CT_AND: if (qp && !cond) begin
               wr = '{we1: 1'b1, we2: 1'b1, v1: 1'b0, v2: 1'b0};
            end
            CT_OR: if (qp && cond) begin
               wr = '{we1: 1'b1, we2: 1'b1, v1: 1'b1, v2: 1'b1};
            end
            CT_ANDORCM: if (qp && !cond) begin
               wr = '{we1: 1'b1, we2: 1'b1, v1: 1'b0, v2: 1'b1};
            end
            CT_ORANDCM: if (qp && cond) begin
               wr = '{we1: 1'b1, we2: 1'b1, v1: 1'b1, v2: 1'b0};
            end
            default: wr = '0;
         endcase
      end
   end

   // R3
   cmp_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && qp && (ctype == 3'd0 || ctype == 3'd1)) |-> (wr.we1 && wr.we2 && (wr.v1 != wr.v2)));

   // R4
   unc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !qp && ctype == 3'd1) |-> (wr.we1 && wr.we2 && !wr.v1 && !wr.v2));

   // R12
   par_qp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!valid) || (ctype != 3'd1 && !qp) || ctype[2:1] == 2'b11) |-> (!wr.we1 && !wr.we2));

endmodule

// File: rtl/pcmp_pred_file.sv
module pcmp_pred_file #(
   parameter int NPRED  = 64,
   parameter int PIDX_W = 6,
   parameter int NLANE  = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  pcmp_pkg::pwr_t [NLANE-1:0]        wr,
   input  logic [NLANE-1:0][PIDX_W-1:0]      wr_t1,
   input  logic [NLANE-1:0][PIDX_W-1:0]      wr_t2,
   input  logic [NLANE-1:0][PIDX_W-1:0]      qp_idx,
   output logic [NLANE-1:0]                  qp_val,
   input  logic [PIDX_W-1:0]                 gd_idx,
   output logic                              gd_val,
   output logic [NPRED-1:0]                  pred_q
);
   localparam logic [NPRED-1:0] RST_VAL = {{(NPRED-1){1'b0}}, 1'b1};

   logic [NPRED-1:0] pred_nxt;
   logic             any_we;

   always_comb begin
      pred_nxt = pred_q;
      any_we   = 1'b0;
      for (int l = 0; l < NLANE; l++) begin
         if (wr[l].we1) pred_nxt[wr_t1[l]] = wr[l].v1;
         if (wr[l].we2) pred_nxt[wr_t2[l]] = wr[l].v2;
         any_we = any_we | wr[l].we1 | wr[l].we2;
      end
      pred_nxt[0] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pred_q <= RST_VAL;
      else        pred_q <= pred_nxt;
   end

   generate
      for (genvar l = 0; l < NLANE; l++) begin : g_qp
         assign qp_val[l] = pred_q[qp_idx[l]];
      end
   endgenerate

   assign gd_val = pred_q[gd_idx];

   // R2
   p0_const_chk: assert property (@(posedge clk) disable iff (!rst_n) pred_q[0]);

   // R12
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_we |=> (pred_q == $past(pred_q)));

   // R11
   top_lane_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr[NLANE-1].we2 && wr_t2[NLANE-1] != '0) |=>
         (pred_q[$past(wr_t2[NLANE-1])] == $past(wr[NLANE-1].v2)));

endmodule

// File: rtl/pcmp_unit.sv
module pcmp_unit #(
   parameter int NPRED  = 64,
   parameter int PIDX_W = $clog2(NPRED),
   parameter int DATA_W = 64,
   parameter int IMM_W  = 14,
   parameter int NLANE  = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NLANE-1:0]                  cmp_valid,
   input  logic [NLANE-1:0][2:0]             cmp_type,
   input  logic [NLANE-1:0][1:0]             cmp_rel,
   input  logic [NLANE-1:0]                  cmp_imm_sel,
   input  logic [NLANE-1:0][IMM_W-1:0]       cmp_imm,
   input  logic [NLANE-1:0][DATA_W-1:0]      cmp_opa,
   input  logic [NLANE-1:0][DATA_W-1:0]      cmp_opb,
   input  logic [NLANE-1:0][PIDX_W-1:0]      cmp_qp,
   input  logic [NLANE-1:0][PIDX_W-1:0]      cmp_t1,
   input  logic [NLANE-1:0][PIDX_W-1:0]      cmp_t2,
   input  logic                              cons_valid,
   input  logic [PIDX_W-1:0]                 cons_qp,
   output logic                              cons_en,
   output logic [NPRED-1:0]                  pred_vec
);
   generate
      if (NPRED < 2 || NPRED != (1 << PIDX_W)) begin : g_bad_npred
         $error("pcmp_unit: NPRED must be a power of two >= 2 matching PIDX_W");
      end
      if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm
         $error("pcmp_unit: IMM_W must lie in 1..DATA_W");
      end
      if (NLANE < 1) begin : g_bad_lane
         $error("pcmp_unit: NLANE must be at least 1");
      end
   endgenerate

   pcmp_pkg::pwr_t [NLANE-1:0] lane_wr;
   logic [NLANE-1:0]           lane_qp;
   logic [NLANE-1:0]           lane_cond;
   logic                       gd_val;

   generate
      for (genvar l = 0; l < NLANE; l++) begin : g_lane
         pcmp_cond #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_cond (
            .rel     (cmp_rel[l]),
            .imm_sel (cmp_imm_sel[l]),
            .imm     (cmp_imm[l]),
            .opa     (cmp_opa[l]),
            .opb     (cmp_opb[l]),
            .cond    (lane_cond[l])
         );
         pcmp_lane_upd u_upd (
            .clk   (clk),
            .rst_n (rst_n),
            .valid (cmp_valid[l]),
            .ctype (cmp_type[l]),
            .qp    (lane_qp[l]),
            .cond  (lane_cond[l]),
            .wr    (lane_wr[l])
         );
      end
   endgenerate

   pcmp_pred_file #(.NPRED(NPRED), .PIDX_W(PIDX_W), .NLANE(NLANE)) u_file (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (lane_wr),
      .wr_t1  (cmp_t1),
      .wr_t2  (cmp_t2),
      .qp_idx (cmp_qp),
      .qp_val (lane_qp),
      .gd_idx (cons_qp),
      .gd_val (gd_val),
      .pred_q (pred_vec)
   );

   assign cons_en = cons_valid & gd_val;

endmodule

// File: tb/tb_pcmp_unit.sv
module tb_pcmp_unit;
   localparam int CLK_P  = 10;
   localparam int NPRED  = 64;
   localparam int PIDX_W = 6;
   localparam int DATA_W = 64;
   localparam int IMM_W  = 14;
   localparam int NLANE  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NLANE-1:0]             cmp_valid;
   logic [NLANE-1:0][2:0]        cmp_type;
   logic [NLANE-1:0][1:0]        cmp_rel;
   logic [NLANE-1:0]             cmp_imm_sel;
   logic [NLANE-1:0][IMM_W-1:0]  cmp_imm;
   logic [NLANE-1:0][DATA_W-1:0] cmp_opa;
   logic [NLANE-1:0][DATA_W-1:0] cmp_opb;
   logic [NLANE-1:0][PIDX_W-1:0] cmp_qp;
   logic [NLANE-1:0][PIDX_W-1:0] cmp_t1;
   logic [NLANE-1:0][PIDX_W-1:0] cmp_t2;
   logic                         cons_valid;
   logic [PIDX_W-1:0]            cons_qp;
   logic                         cons_en;
   logic [NPRED-1:0]             pred_vec;

   logic [NPRED-1:0] exp_p;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   pcmp_unit #(.NPRED(NPRED), .PIDX_W(PIDX_W), .DATA_W(DATA_W), .IMM_W(IMM_W), .NLANE(NLANE)) dut (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_type(cmp_type), .cmp_rel(cmp_rel),
      .cmp_imm_sel(cmp_imm_sel), .cmp_imm(cmp_imm), .cmp_opa(cmp_opa), .cmp_opb(cmp_opb),
      .cmp_qp(cmp_qp), .cmp_t1(cmp_t1), .cmp_t2(cmp_t2), .cons_valid(cons_valid),
      .cons_qp(cons_qp), .cons_en(cons_en), .pred_vec(pred_vec)
   );

   function automatic logic cond_f(input logic [1:0] rel, input logic isel,
                                   input logic [IMM_W-1:0] imm,
                                   input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
      logic signed [DATA_W-1:0] sa;
      logic signed [DATA_W-1:0] sb;
      sa = isel ? DATA_W'($signed(imm)) : a;
      sb = b;
      case (rel)
         2'd0:    return sa == sb;
         2'd1:    return sa != sb;
         2'd2:    return sa < sb;
         default: return sa >= sb;
      endcase
   endfunction

   task automatic model_step();
      logic [NPRED-1:0] old;
      old = exp_p;
      for (int l = 0; l < NLANE; l++) begin
         logic q, c, w1, w2, v1, v2;
         q = old[cmp_qp[l]];
         c = cond_f(cmp_rel[l], cmp_imm_sel[l], cmp_imm[l], cmp_opa[l], cmp_opb[l]);
         w1 = 0; w2 = 0; v1 = 0; v2 = 0;
         if (cmp_valid[l]) begin
            case (cmp_type[l])
               3'd0: if (q) begin w1 = 1; w2 = 1; v1 = c; v2 = !c; end
               3'd1: begin w1 = 1; w2 = 1; v1 = q && c; v2 = q && !c; end
               3'd2: if (q && !c) begin w1 = 1; w2 = 1; v1 = 0; v2 = 0; end
               3'd3: if (q && c) begin w1 = 1; w2 = 1; v1 = 1; v2 = 1; end
               3'd4: if (q && !c) begin w1 = 1; w2 = 1; v1 = 0; v2 = 1; end
               3'd5: if (q && c) begin w1 = 1; w2 = 1; v1 = 1; v2 = 0; end
               default: ;
            endcase
         end
         if (w1 && cmp_t1[l] != 0) exp_p[cmp_t1[l]] = v1;
         if (w2 && cmp_t2[l] != 0) exp_p[cmp_t2[l]] = v2;
      end
   endtask

   task automatic clear_in();
      cmp_valid = '0; cmp_type = '0; cmp_rel = '0; cmp_imm_sel = '0; cmp_imm = '0;
      cmp_opa = '0; cmp_opb = '0; cmp_qp = '0; cmp_t1 = '0; cmp_t2 = '0;
      cons_valid = 1'b0; cons_qp = '0;
   endtask

   task automatic set_lane(input int l, input logic [2:0] ty, input logic [1:0] rel,
                           input logic isel, input logic [IMM_W-1:0] imm,
                           input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                           input int qp, input int t1, input int t2);
      cmp_valid[l] = 1'b1; cmp_type[l] = ty; cmp_rel[l] = rel; cmp_imm_sel[l] = isel;
      cmp_imm[l] = imm; cmp_opa[l] = a; cmp_opb[l] = b;
      cmp_qp[l] = PIDX_W'(qp); cmp_t1[l] = PIDX_W'(t1); cmp_t2[l] = PIDX_W'(t2);
   endtask

   task automatic chk_vec(input string req);
      checks++;
      if (pred_vec !== exp_p) begin
         errors++;
         $display("FAIL %s: pred_vec actual %h expected %h", req, pred_vec, exp_p);
      end
   endtask

   task automatic chk_bit(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic tick(input string req);
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk_vec(req);
      clear_in();
   endtask

   function automatic logic [DATA_W-1:0] pick_val();
      case ($urandom_range(0, 3))
         0: return '0;
         1: return 64'd1;
         2: return 64'd2;
         default: return '1;
      endcase
   endfunction

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      clear_in();
      exp_p = {{(NPRED-1){1'b0}}, 1'b1};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_vec("R1");

      // R2 write to index 0 discarded, p3 gets 1
      set_lane(0, 3'd0, 2'd1, 0, 0, 64'd5, 64'd5, 0, 0, 3);
      tick("R2");
      chk_bit("R2", pred_vec[0], 1'b1);
      chk_bit("R2", pred_vec[3], 1'b1);

      // R3 normal with true qp
      set_lane(0, 3'd0, 2'd0, 0, 0, 64'd7, 64'd7, 0, 1, 2);
      tick("R3");
      chk_bit("R3", pred_vec[1], 1'b1);
      // R3 normal with false qp (p2 == 0) leaves p1/p2
      set_lane(0, 3'd0, 2'd1, 0, 0, 64'd7, 64'd7, 2, 1, 2);
      tick("R3");

      // R4 unconditional with false qp clears both targets
      set_lane(0, 3'd1, 2'd0, 0, 0, 64'd1, 64'd1, 2, 3, 4);
      tick("R4");
      chk_bit("R4", pred_vec[3], 1'b0);

      // R6 OR type sets both
      set_lane(0, 3'd3, 2'd0, 0, 0, 64'd9, 64'd9, 0, 20, 21);
      tick("R6");
      chk_bit("R6", pred_vec[21], 1'b1);
      // R5 AND type with false condition clears both
      set_lane(0, 3'd2, 2'd1, 0, 0, 64'd9, 64'd9, 0, 20, 21);
      tick("R5");
      chk_bit("R5", pred_vec[20], 1'b0);

      // R7 R11 four-way AND/NAND: init pair, then all conditions true
      set_lane(0, 3'd1, 2'd0, 0, 0, 0, 0, 0, 10, 11);
      tick("R11");
      for (int l = 0; l < NLANE; l++) set_lane(l, 3'd4, 2'd0, 0, 0, 64'(l), 64'(l), 0, 10, 11);
      tick("R7");
      chk_bit("R11", pred_vec[10], 1'b1);
      for (int l = 0; l < NLANE; l++) set_lane(l, 3'd4, 2'd0, 0, 0, 64'(l), (l == 2) ? 64'd99 : 64'(l), 0, 10, 11);
      tick("R7");
      chk_bit("R11", pred_vec[10], 1'b0);
      chk_bit("R11", pred_vec[11], 1'b1);

      // R8 or.andcm: init 12=0,13=1 then one true lane
      set_lane(0, 3'd0, 2'd1, 0, 0, 0, 0, 0, 12, 13);
      tick("R8");
      set_lane(0, 3'd5, 2'd1, 0, 0, 0, 0, 0, 12, 13);
      set_lane(1, 3'd5, 2'd0, 0, 0, 64'd4, 64'd4, 0, 12, 13);
      tick("R8");
      chk_bit("R8", pred_vec[12], 1'b1);
      chk_bit("R8", pred_vec[13], 1'b0);

      // R9 signed relations: -1 < 1 true, -1 >= 1 false
      set_lane(0, 3'd0, 2'd2, 0, 0, '1, 64'd1, 0, 30, 31);
      set_lane(1, 3'd0, 2'd3, 0, 0, '1, 64'd1, 0, 32, 33);
      tick("R9");
      chk_bit("R9", pred_vec[30], 1'b1);
      chk_bit("R9", pred_vec[32], 1'b0);

      // R10 immediate -5 sign-extended equals register -5
      set_lane(0, 3'd0, 2'd0, 1, -14'sd5, 64'd0, -64'sd5, 0, 34, 35);
      tick("R10");
      chk_bit("R10", pred_vec[34], 1'b1);

      // R11 lane priority: lane1 overrides lane0 on index 40
      set_lane(0, 3'd0, 2'd0, 0, 0, 0, 0, 0, 40, 41);
      set_lane(1, 3'd0, 2'd1, 0, 0, 0, 0, 0, 40, 42);
      tick("R11");
      chk_bit("R11", pred_vec[40], 1'b0);

      // R12 reserved type code and low valid never write
      set_lane(0, 3'd6, 2'd0, 0, 0, 0, 0, 0, 1, 10);
      set_lane(1, 3'd3, 2'd0, 0, 0, 0, 0, 0, 5, 6);
      cmp_valid[1] = 1'b0;
      tick("R12");

      // R13 guard before the landing update
      set_lane(0, 3'd0, 2'd1, 0, 0, 0, 0, 0, 1, 2);
      cons_valid = 1'b1; cons_qp = 6'd1;
      #1 chk_bit("R13", cons_en, 1'b1);
      tick("R13");
      cons_valid = 1'b1; cons_qp = 6'd1;
      #1 chk_bit("R13", cons_en, 1'b0);
      cons_valid = 1'b0; cons_qp = 6'd2;
      #1 chk_bit("R13", cons_en, 1'b0);

      // random mix, R3..R13 against the model
      for (int n = 0; n < 400; n++) begin
         clear_in();
         for (int l = 0; l < NLANE; l++) begin
            cmp_valid[l]   = ($urandom_range(0, 3) != 0);
            cmp_type[l]    = 3'($urandom_range(0, 7));
            cmp_rel[l]     = 2'($urandom_range(0, 3));
            cmp_imm_sel[l] = ($urandom_range(0, 3) == 0);
            cmp_imm[l]     = IMM_W'(pick_val());
            cmp_opa[l]     = pick_val();
            cmp_opb[l]     = pick_val();
            cmp_qp[l]      = PIDX_W'($urandom_range(0, 15));
            cmp_t1[l]      = PIDX_W'($urandom_range(0, 15));
            cmp_t2[l]      = PIDX_W'($urandom_range(0, 15));
         end
         cons_valid = ($urandom_range(0, 1) == 1);
         cons_qp    = PIDX_W'($urandom_range(0, 15));
         #1 chk_bit("R13", cons_en, cons_valid & exp_p[cons_qp]);
         tick("R11");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule